// File: doc/BRIEF.md
# UART Interrupt and Low-Power Controller

This block sits beside a UART's serial shifters. It holds the eight status flags the UART raises, gates each flag with its own enable, and merges the gated flags into one active-high interrupt request. Each flag stays set until a one-cycle clear strobe for that flag arrives. If a set and a clear arrive in the same cycle, the flag ends up set.

The block also decides when the UART's gated clock may run. In stop mode the UART clock is always off. In wait mode it is off only when a halt option is set. Everything in this block runs on an always-on clock, so the receive-line edge detector keeps working while the UART is frozen. The detector feeds the active-edge flag, and while the UART clock is gated it raises a wake request. Leaving a low-power mode by reset resets the flags and sends a one-cycle abort strobe that resets the UART and throws away any transfer in progress.

Top module: `uart_irq_pwr`

## Requirements
- R1: While `rst_n` is low, `irq`, `uclk_en` and `wake_req` are 0, `abort` is 1 and every flag is cleared.
- R2: The flags use these bit positions: 0 transmit empty, 1 transmit complete, 2 receive full, 3 overrun, 4 idle line, 5 receive active edge, 6 bit error, 7 break. A 1 on `src_set[i]` at a clock edge sets flag i. The flag then holds until a clock edge where `src_clr[i]` is 1.
- R3: If `src_set[i]` and `src_clr[i]` are both 1 at the same edge, flag i is set after that edge.
- R4: `irq` is the combinational OR of the enabled flags. The `irq_en` bits are: 0 transmit empty, 1 transmit complete, 2 receive, 3 idle, 4 active edge, 5 bit error, 6 break. If a flag's enable bit is 0, that flag cannot drive `irq`.
- R5: `irq_en[2]` enables both the receive-full flag (bit 2) and the overrun flag (bit 3).
- R6: `rxd` passes through a two-stage synchronizer. A falling edge on `rxd` when `rx_pol`=0, or a rising edge when `rx_pol`=1, sets flag 5 at the third clock edge after the change. An edge of the other direction does not set flag 5.
- R7: One edge after `stop_mode` is 1, `uclk_en` is 0, whatever `wait_halt` is.
- R8: In wait mode with `wait_halt`=0, `uclk_en` stays 1. In wait mode with `wait_halt`=1, `uclk_en` is 0 one edge later. When the modes clear, `uclk_en` returns to 1 one edge later.
- R9: If an active edge is detected while the UART clock is gated, `wake_req` goes to 1 at the same edge as flag 5. `wake_req` stays 1 until the clock is ungated, and it is never set while the UART clock runs.
- R10: After `rst_n` is released, `abort` falls at the first clock edge and then stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | 8 | Per-flag set pulses from the UART |
| src_clr | input | 8 | Per-flag one-cycle clear strobes |
| irq_en | input | 7 | Local interrupt enables |
| rx_pol | input | 1 | Receive polarity: 0 falling edge active, 1 rising edge active |
| rxd | input | 1 | Asynchronous receive pin |
| wait_mode | input | 1 | CPU is in wait mode |
| wait_halt | input | 1 | Gate the UART clock during wait mode |
| stop_mode | input | 1 | CPU is in stop mode |
| irq | output | 1 | Combined interrupt request |
| uclk_en | output | 1 | Enable for the UART's gated clock |
| wake_req | output | 1 | Wake request from a receive edge while gated |
| abort | output | 1 | Abort/reset strobe to the UART |

## Verification
The bench builds the block with the default two-stage synchronizer. At that depth the edge-to-flag latency is three edges, so the bench checks both the cycle before the flag sets and the cycle it sets. Holding the other parameters at their defaults lets the vector table cover every flag position and every enable bit, including the shared receive enable. Directed tests then cover both polarities, the wrong-direction edges, and wake requests with the clock gated and with it running.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int unsigned NSRC     = 8;
  localparam int unsigned NEN      = 7;
  localparam int unsigned SRC_EDGE = 5;
  localparam int unsigned SRC_OVR  = 3;

  // Flags below the overrun slot map one-to-one onto enables; from the
  // overrun slot upward the index shifts down by one (overrun shares bit 2).
  function automatic int unsigned en_index(input int unsigned src);
    return (src < SRC_OVR) ? src : src - 1;
  endfunction
endpackage

// File: rtl/uirq_flags.sv
module uirq_flags #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] flag_o
);
  logic [NSRC-1:0] flag_d, flag_q;

  always_comb begin
    flag_d = set_i | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/uirq_rxedge.sv
module uirq_rxedge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd_i,
  input  logic pol_i,
  output logic hit_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_d, sync_q;
  logic                   prev_d, prev_q;

  always_comb begin
    sync_d[0] = rxd_i;
    for (int i = 1; i < SYNC_STAGES; i++) sync_d[i] = sync_q[i-1];
    prev_d = sync_q[LAST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  always_comb begin
    if (pol_i) hit_o = ~prev_q & sync_q[LAST];
    else       hit_o = prev_q & ~sync_q[LAST];
  end
endmodule

// File: rtl/uirq_pwr.sv
module uirq_pwr (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_i,
  input  logic wait_i,
  input  logic halt_i,
  input  logic hit_i,
  output logic uclk_en_o,
  output logic wake_o,
  output logic abort_o
);
  logic gated;
  logic run_d, run_q;
  logic wake_d, wake_q;
  logic abort_d, abort_q;

  always_comb begin
    gated   = stop_i | (wait_i & halt_i);
    run_d   = ~gated;
    wake_d  = gated & (wake_q | hit_i);
    abort_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      wake_q  <= 1'b0;
      abort_q <= 1'b1;
    end else begin
      run_q   <= run_d;
      wake_q  <= wake_d;
      abort_q <= abort_d;
    end
  end

  assign uclk_en_o = run_q;
  assign wake_o    = wake_q;
  assign abort_o   = abort_q;
endmodule

// File: rtl/uart_irq_pwr.sv
module uart_irq_pwr
  import uirq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_set,
  input  logic [NSRC-1:0] src_clr,
  input  logic [NEN-1:0]  irq_en,
  input  logic            rx_pol,
  input  logic            rxd,
  input  logic            wait_mode,
  input  logic            wait_halt,
  input  logic            stop_mode,
  output logic            irq,
  output logic            uclk_en,
  output logic            wake_req,
  output logic            abort
);
  logic            edge_hit;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] en_vec;

  uirq_rxedge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .rxd_i (rxd),
    .pol_i (rx_pol),
    .hit_o (edge_hit)
  );

  always_comb begin
    set_vec           = src_set;
    set_vec[SRC_EDGE] = src_set[SRC_EDGE] | edge_hit;
  end

  uirq_flags #(.NSRC(NSRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (src_clr),
    .flag_o (flag_q)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_en
    assign en_vec[g] = irq_en[en_index(g)];
  end

  assign irq = |(flag_q & en_vec);

  uirq_pwr u_pwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_i    (stop_mode),
    .wait_i    (wait_mode),
    .halt_i    (wait_halt),
    .hit_i     (edge_hit),
    .uclk_en_o (uclk_en),
    .wake_o    (wake_req),
    .abort_o   (abort)
  );
endmodule

// File: rtl/uirq_chk.sv
module uirq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] src_set,
  input logic [7:0] src_clr,
  input logic       wait_mode,
  input logic       wait_halt,
  input logic       stop_mode,
  input logic       irq,
  input logic       uclk_en,
  input logic       wake_req,
  input logic       abort,
  input logic [7:0] flag_q
);
  // R3: a set pulse always leaves its flag set, even with a clear in the same cycle
  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_set) |=> ((flag_q & $past(src_set)) == $past(src_set)));

  // R2: a set flag with no clear strobe stays set
  p_flag_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_q & ~src_clr)) |=> ((flag_q & $past(flag_q & ~src_clr)) == $past(flag_q & ~src_clr)));

  // R4: no request without a pending flag
  p_irq_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|flag_q));

  // R7: stop mode always gates the UART clock
  p_stop_gates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |=> !uclk_en);

  // R8: wait mode without the halt option keeps the clock running
  p_wait_runs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_mode && !wait_halt && !stop_mode) |=> uclk_en);

  // R9: no wake request while the UART clock runs
  p_wake_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_mode && !(wait_mode && wait_halt)) |=> !wake_req);

  // R10: the abort strobe lasts a single cycle after reset
  p_abort_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);
endmodule

bind uart_irq_pwr uirq_chk u_chk (.*);

// File: tb/uart_irq_pwr_test.sv
module uart_irq_pwr_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  // {set[7:0], en[6:0], expected irq}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'h01, 7'h01, 1'b1},
    {8'h01, 7'h7E, 1'b0},
    {8'h02, 7'h02, 1'b1},
    {8'h04, 7'h04, 1'b1},
    {8'h08, 7'h04, 1'b1},
    {8'h08, 7'h7B, 1'b0},
    {8'h10, 7'h08, 1'b1},
    {8'h20, 7'h10, 1'b1},
    {8'h40, 7'h20, 1'b1},
    {8'h80, 7'h40, 1'b1},
    {8'h80, 7'h3F, 1'b0},
    {8'h00, 7'h7F, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] src_set, src_clr;
  logic [6:0] irq_en;
  logic       rx_pol, rxd, wait_mode, wait_halt, stop_mode;
  logic       irq, uclk_en, wake_req, abort;

  int n_chk = 0;
  int n_bad = 0;

  uart_irq_pwr uut (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
    .irq_en(irq_en), .rx_pol(rx_pol), .rxd(rxd), .wait_mode(wait_mode),
    .wait_halt(wait_halt), .stop_mode(stop_mode), .irq(irq),
    .uclk_en(uclk_en), .wake_req(wake_req), .abort(abort)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_all();
    src_clr = 8'hFF; src_set = 8'h00;
    step(1);
    src_clr = 8'h00;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_set = '0; src_clr = '0; irq_en = '0;
    rx_pol = 1'b0; rxd = 1'b1; wait_mode = 1'b0; wait_halt = 1'b0; stop_mode = 1'b0;
    step(3);
    check("R1 irq", irq, 1'b0);
    check("R1 uclk_en", uclk_en, 1'b0);
    check("R1 wake_req", wake_req, 1'b0);
    check("R1 abort", abort, 1'b1);
    rst_n = 1'b1;
    check("R10 abort before first edge", abort, 1'b1);
    step(1);
    check("R10 abort falls", abort, 1'b0);
    check("R8 clock runs after reset", uclk_en, 1'b1);
    step(2);
    check("R10 abort stays low", abort, 1'b0);

    // Vector table: R2 set positions, R4 enable mapping, R5 shared receive enable
    for (int v = 0; v < NVEC; v++) begin
      clear_all();
      src_set = VEC[v][15:8];
      irq_en  = VEC[v][7:1];
      step(1);
      src_set = 8'h00;
      check("R4/R5 vector irq", irq, VEC[v][0]);
      step(2);
      check("R2 flag holds", irq, VEC[v][0]);
    end

    // R3: set and clear together
    clear_all();
    irq_en = 7'h01;
    src_set = 8'h01; src_clr = 8'h01;
    step(1);
    src_set = 8'h00; src_clr = 8'h00;
    check("R3 set wins", irq, 1'b1);
    src_clr = 8'h01;
    step(1);
    src_clr = 8'h00;
    check("R2 clear strobe", irq, 1'b0);

    // R6: falling edge, polarity 0
    clear_all();
    irq_en = 7'h10; rx_pol = 1'b0;
    rxd = 1'b0;
    step(2);
    check("R6 fall not yet", irq, 1'b0);
    step(1);
    check("R6 fall sets flag", irq, 1'b1);
    check("R9 no wake while running", wake_req, 1'b0);
    clear_all();
    rxd = 1'b1;
    step(4);
    check("R6 rise ignored pol0", irq, 1'b0);
    // polarity 1
    rx_pol = 1'b1;
    rxd = 1'b0;
    step(4);
    check("R6 fall ignored pol1", irq, 1'b0);
    rxd = 1'b1;
    step(3);
    check("R6 rise sets flag pol1", irq, 1'b1);
    clear_all();

    // R7 and R9: stop mode, wake by receive edge
    rx_pol = 1'b0; wait_halt = 1'b0;
    stop_mode = 1'b1;
    step(1);
    check("R7 stop gates clock", uclk_en, 1'b0);
    check("R9 no wake yet", wake_req, 1'b0);
    rxd = 1'b0;
    step(2);
    check("R9 wake not yet", wake_req, 1'b0);
    step(1);
    check("R9 wake set in stop", wake_req, 1'b1);
    check("R6 edge flag in stop", irq, 1'b1);
    step(2);
    check("R9 wake held", wake_req, 1'b1);
    stop_mode = 1'b0;
    step(1);
    check("R9 wake clears on run", wake_req, 0);
    check("R7 clock resumes", uclk_en, 1'b1);
    clear_all();
    rxd = 1'b1;
    step(4);

    // R8: wait mode with and without halt option
    wait_mode = 1'b1; wait_halt = 1'b0;
    step(2);
    check("R8 wait no halt runs", uclk_en, 1'b1);
    wait_halt = 1'b1;
    step(1);
    check("R8 wait halt gates", uclk_en, 1'b0);
    rxd = 1'b0;
    step(3);
    check("R9 wake in halted wait", wake_req, 1'b1);
    wait_mode = 1'b0;
    step(1);
    check("R8 resume after wait", uclk_en, 1'b1);
    check("R9 wake clears after wait", wake_req, 1'b0);
    wait_halt = 1'b0;

    // R1: reset while in stop mode
    stop_mode = 1'b1;
    step(2);
    rst_n = 1'b0;
    step(1);
    check("R1 abort in reset", abort, 1'b1);
    check("R1 irq cleared", irq, 1'b0);
    stop_mode = 1'b0;
    rst_n = 1'b1;
    step(1);
    check("R10 abort after second reset", abort, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule